// File: doc/BRIEF.md
# Carry-Save 4:2 Compressor Row

This block reduces four operand words of equal width to a redundant pair, a sum vector and a carry vector, without any carry travelling along the word. Every bit position holds one compressor cell made of two full adders in cascade. The first adder takes three of the four operand bits and produces an intermediate sum and a lateral carry that goes to the next more significant cell. The second adder combines the intermediate sum, the fourth operand bit and the lateral carry arriving from the less significant cell. Its outputs are the sum bit and the carry bit of the position.

Each lateral carry depends only on the operand bits of its own column. The chain between cells therefore has a depth of one cell, whatever the row width. The row has a lateral carry input at the least significant end and a lateral carry output at the most significant end. Rows can be placed side by side, or the input can be used to inject a single extra unit. The block is purely combinational. The redundant result is meant for a later compression stage or a final carry-propagate adder, and neither is part of this block.

Top module: `csa42_row`

## Requirements
- R1: For all inputs, sum_o + 2*carry_o + 2^N*lat_cout equals in_w + in_x + in_y + in_z + lat_cin. All values are taken as unsigned.
- R2: lat_cout equals the majority of in_w[N-1], in_x[N-1] and in_y[N-1]. The value of lat_cin has no effect on it.
- R3: A change on lat_cin alone leaves sum_o[N-1:1] and carry_o[N-1:1] unchanged. Only bit 0 of the sum vector and bit 0 of the carry vector can change.
- R4: A change on the four operand bits of column j alone leaves the sum and carry bits of every column other than j and j+1 unchanged. For j < N-1 it also leaves lat_cout unchanged.
- R5: When all operands are zero and lat_cin is 0, sum_o, carry_o and lat_cout are all zero.
- R6: When all operand bits are one and lat_cin is 1, sum_o, carry_o and lat_cout are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_w | input | N | Operand word, fed to the first adder of each cell |
| in_x | input | N | Operand word, fed to the first adder of each cell |
| in_y | input | N | Operand word, fed to the first adder of each cell |
| in_z | input | N | Operand word, fed to the second adder of each cell |
| lat_cin | input | 1 | Lateral carry into the least significant cell, weight 1 |
| sum_o | output | N | Sum vector, bit i has weight 2^i |
| carry_o | output | N | Carry vector, bit i has weight 2^(i+1) |
| lat_cout | output | 1 | Lateral carry out of the most significant cell, weight 2^N |

## Verification
Every combination of the four 4-bit operands is applied twice at the default width, once with each value of the lateral carry input. This checks the weighted identity for every input value. Each pair of applications is also compared bit by bit: the comparison separates a correct row from one whose upper bits or end carry respond to the carry input, which is how a rippling chain would show itself. A second sweep flips single columns on a range of base vectors. It catches any cell that takes data from a column more than one position away. Two fixed patterns, all zeros and all ones, check that nothing is offset or inverted.

// File: rtl/csa42_pkg.sv
package csa42_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    typedef struct packed {
        logic w;
        logic x;
        logic y;
        logic z;
    } col_t;

    function automatic fa_out_t fa_eval(input logic a, input logic b, input logic c);
        fa_out_t r;
        r.s = a ^ b ^ c;
        r.c = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/csa42_fa.sv
module csa42_fa
    import csa42_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);
    fa_out_t res;

    always_comb begin
        res  = fa_eval(a_i, b_i, c_i);
        s_o  = res.s;
        co_o = res.c;
    end
endmodule

// File: rtl/csa42_cell.sv
module csa42_cell
    import csa42_pkg::*;
(
    input  col_t col_i,
    input  logic lat_i,
    output logic sum_o,
    output logic carry_o,
    output logic lat_o
);
    logic mid_s;

    // first stage: three operand bits only, lateral out never sees lat_i
    csa42_fa u_fa_lo (
        .a_i  (col_i.w),
        .b_i  (col_i.x),
        .c_i  (col_i.y),
        .s_o  (mid_s),
        .co_o (lat_o)
    );

    // second stage: intermediate sum, fourth operand, incoming lateral carry
    csa42_fa u_fa_hi (
        .a_i  (mid_s),
        .b_i  (col_i.z),
        .c_i  (lat_i),
        .s_o  (sum_o),
        .co_o (carry_o)
    );
endmodule

// File: rtl/csa42_row.sv
module csa42_row
    import csa42_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] in_w,
    input  logic [N-1:0] in_x,
    input  logic [N-1:0] in_y,
    input  logic [N-1:0] in_z,
    input  logic         lat_cin,
    output logic [N-1:0] sum_o,
    output logic [N-1:0] carry_o,
    output logic         lat_cout
);
    localparam int CHAIN_W = N + 1;

    logic [CHAIN_W-1:0] lat_chain;
    col_t [N-1:0]       cols;

    assign lat_chain[0] = lat_cin;
    assign lat_cout     = lat_chain[N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        assign cols[i] = '{w: in_w[i], x: in_x[i], y: in_y[i], z: in_z[i]};

        csa42_cell u_cell (
            .col_i   (cols[i]),
            .lat_i   (lat_chain[i]),
            .sum_o   (sum_o[i]),
            .carry_o (carry_o[i]),
            .lat_o   (lat_chain[i+1])
        );
    end
endmodule

// File: rtl/csa42_row_chk.sv
module csa42_row_chk #(
    parameter int N = 4
) (
    input logic [N-1:0] in_w,
    input logic [N-1:0] in_x,
    input logic [N-1:0] in_y,
    input logic [N-1:0] in_z,
    input logic         lat_cin,
    input logic [N-1:0] sum_o,
    input logic [N-1:0] carry_o,
    input logic         lat_cout
);
    localparam int WW = N + 3;

    logic [WW-1:0] lhs, rhs;

    always_comb begin
        lhs = WW'(sum_o) + (WW'(carry_o) << 1) + (WW'(lat_cout) << N);
        rhs = WW'(in_w) + WW'(in_x) + WW'(in_y) + WW'(in_z) + WW'(lat_cin);
        AST_SUM_IDENTITY: assert (lhs == rhs); // R1
        AST_END_CARRY_MAJ: assert (lat_cout ==
            ((in_w[N-1] & in_x[N-1]) | (in_w[N-1] & in_y[N-1]) | (in_x[N-1] & in_y[N-1]))); // R2
        if (in_w == '0 && in_x == '0 && in_y == '0 && in_z == '0 && !lat_cin) begin
            AST_ZERO_IN_ZERO_OUT: assert (sum_o == '0 && carry_o == '0 && !lat_cout); // R5
        end
        if (&{in_w, in_x, in_y, in_z, lat_cin}) begin
            AST_ONES_IN_ONES_OUT: assert (&{sum_o, carry_o, lat_cout}); // R6
        end
    end
endmodule

bind csa42_row csa42_row_chk #(.N(N)) u_chk (
    .in_w     (in_w),
    .in_x     (in_x),
    .in_y     (in_y),
    .in_z     (in_z),
    .lat_cin  (lat_cin),
    .sum_o    (sum_o),
    .carry_o  (carry_o),
    .lat_cout (lat_cout)
);

// File: tb/csa42_row_tb.sv
module csa42_row_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] in_w, in_x, in_y, in_z;
    logic lat_cin;
    logic [N-1:0] sum_o, carry_o;
    logic lat_cout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    csa42_row #(.N(N)) u_dut (
        .in_w(in_w), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .lat_cin(lat_cin),
        .sum_o(sum_o), .carry_o(carry_o), .lat_cout(lat_cout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int v, input bit ci);
        in_w    = v[3:0];
        in_x    = v[7:4];
        in_y    = v[11:8];
        in_z    = v[15:12];
        lat_cin = ci;
        #5;
    endtask

    function automatic bit maj3(input bit a, input bit b, input bit c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    initial begin
        in_w = '0; in_x = '0; in_y = '0; in_z = '0; lat_cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5: all-zero state after reset
        check(sum_o == 0 && carry_o == 0 && lat_cout == 0, "R5",
              int'({lat_cout, carry_o, sum_o}), 0);

        // R6: all-ones pattern
        apply(32'hFFFF, 1'b1);
        check(sum_o == 4'hF && carry_o == 4'hF && lat_cout == 1'b1, "R6",
              int'({lat_cout, carry_o, sum_o}), 511);

        // exhaustive sweep: R1, R2, R3
        for (int v = 0; v < 65536; v++) begin
            logic [N-1:0] s0, c0;
            logic         k0;
            s0 = '0; c0 = '0; k0 = 1'b0;
            for (int ci = 0; ci < 2; ci++) begin
                int got, exp;
                apply(v, ci[0]);
                got = int'(sum_o) + 2 * int'(carry_o) + (1 << N) * int'(lat_cout);
                exp = int'(v[3:0]) + int'(v[7:4]) + int'(v[11:8]) + int'(v[15:12]) + ci;
                check(got == exp, "R1", got, exp);
                check(lat_cout == maj3(v[3], v[7], v[11]), "R2",
                      int'(lat_cout), int'(maj3(v[3], v[7], v[11])));
                if (ci == 0) begin
                    s0 = sum_o; c0 = carry_o; k0 = lat_cout;
                end else begin
                    check(sum_o[N-1:1] == s0[N-1:1] && carry_o[N-1:1] == c0[N-1:1], "R3",
                          int'({carry_o[N-1:1], sum_o[N-1:1]}), int'({c0[N-1:1], s0[N-1:1]}));
                    check(lat_cout == k0, "R2", int'(lat_cout), int'(k0));
                end
                #5;
            end
        end

        // R4: column locality
        for (int b = 0; b < 64; b++) begin
            int base;
            base = (b * 16'h9E37 + 16'h1234) & 16'hFFFF;
            for (int j = 0; j < N; j++) begin
                for (int f = 0; f < 2; f++) begin
                    logic [N-1:0] sr, cr, mask;
                    logic         kr;
                    int           flip;
                    apply(base, b[0]);
                    sr = sum_o; cr = carry_o; kr = lat_cout;
                    flip = (f == 0) ? (1 << j) : ((1 << j) | (1 << (j + 4)) | (1 << (j + 8)) | (1 << (j + 12)));
                    apply(base ^ flip, b[0]);
                    mask = '1;
                    mask[j] = 1'b0;
                    if (j + 1 < N) mask[j+1] = 1'b0;
                    check(((sum_o ^ sr) & mask) == 0 && ((carry_o ^ cr) & mask) == 0, "R4",
                          int'({carry_o, sum_o}), int'({cr, sr}));
                    if (j < N - 1)
                        check(lat_cout == kr, "R4", int'(lat_cout), int'(kr));
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule